// File: doc/BRIEF.md
# Phase-Frequency Detector with Test Overrides

This block compares two sampled edge streams, one from the reference divider and one from the feedback divider, and drives pump-up and pump-down requests for a charge pump. All logic runs in one system clock domain. A rising edge on either input counts as an event. The input whose edge arrives first raises its own pump request. That request stays high until the other input produces an edge. Once both requests are high, a reset window of programmable length keeps them both high and then clears them. Together, the held-state behaviour and the saturation on repeated leading edges give the detector a usable range of close to one full period either side of alignment.

For bring-up and test, each pump direction has its own enable, and two force controls can hold one direction high regardless of the comparison. A force-mid control silences both pump outputs and raises a request to bias the loop filter at mid-supply. A lock monitor reports when the one-sided part of each comparison has stayed within one clock cycle for a run of sixteen comparisons.

Top module: `phase_comparator`

## Requirements
- R1: While reset is asserted, pumpUp, pumpDn, midRequest and lockFlag are all 0.
- R2: With no overrides and both enables set, a rising edge on refIn followed S cycles later by a rising edge on fbIn makes pumpUp high for S+D cycles and pumpDn high for D cycles, where D is resetDelay. pumpUp rises two clock edges after the refIn edge is presented.
- R3: The mirror case holds. An fbIn edge followed S cycles later by a refIn edge gives S+D cycles of pumpDn and D cycles of pumpUp.
- R4: After the closing edge, pumpUp and pumpDn are both high for exactly resetDelay cycles (0 to 7) and then both go low. With resetDelay = 0 they never overlap.
- R5: Edges on both inputs in the same cycle give no one-sided pulse. Both outputs are high together for exactly resetDelay cycles.
- R6: A further edge on the leading input before the trailing edge arrives is absorbed. The leading pulse simply continues until the trailing edge.
- R7: Edges that arrive while the reset window is running are ignored and start no new pulse.
- R8: When upEnable is 0, pumpUp is 0 and the detector keeps running. The same applies to dnEnable and pumpDn. Setting an enable again while its direction is still pending makes that output go high one cycle later.
- R9: forceUp alone drives pumpUp=1 and pumpDn=0 from the next cycle on. forceDn alone drives pumpDn=1 and pumpUp=0. Both override the enables and the edge inputs.
- R10: forceMid, or forceUp together with forceDn, drives midRequest=1 and pumpUp=pumpDn=0 from the next cycle on. This takes priority over every other control.
- R11: lockFlag is 1 once the last 16 comparisons each had a one-sided width (S) of at most 1 cycle. A comparison wider than that clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| refIn | input | 1 | Reference-path edge stream |
| fbIn | input | 1 | Feedback-path edge stream |
| resetDelay | input | 3 | Reset-window length in cycles (0 to 7) |
| upEnable | input | 1 | Gate for the pump-up direction |
| dnEnable | input | 1 | Gate for the pump-down direction |
| forceUp | input | 1 | Hold pump-up active |
| forceDn | input | 1 | Hold pump-down active |
| forceMid | input | 1 | Silence both pumps and request mid-supply bias |
| pumpUp | output | 1 | Pump-up request |
| pumpDn | output | 1 | Pump-down request |
| midRequest | output | 1 | Mid-supply bias request |
| lockFlag | output | 1 | Comparison width has stayed within tolerance |

## Verification
If the detector state goes wrong, the pulse-width counts show it in the first comparison after the fault. A stuck state shows up as a count that is too long or never ends, and a lost edge shows up as a missing pulse, both within S+D+2 cycles of the edge. A wrong reset-window counter changes the overlap count by the same number of cycles as its error, which the sweep over every delay value exposes. Errors in override priority appear one clock after the control is applied, and a bad lock counter shows up when the sixteenth tight comparison arrives.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_UP   = 2'd1,
    PH_DN   = 2'd2,
    PH_RST  = 2'd3
  } phState_t;

  // strobes from the control FSM to the output datapath
  typedef struct packed {
    logic upRaw;     // up direction requested by detector
    logic dnRaw;     // down direction requested by detector
    logic oneSided;  // exactly one direction pending this cycle
    logic cmpDone;   // a comparison closed on the previous edge
  } pfdStrobe_t;

endpackage

// File: rtl/pfd_control.sv
module pfd_control
  import pfd_pkg::*;
#(
  parameter int DELAY_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refIn,
  input  logic               fbIn,
  input  logic [DELAY_W-1:0] resetDelay,
  output pfdStrobe_t         strobe
);

  logic refPrev, fbPrev;
  logic refEdge, fbEdge;
  phState_t state, stateNxt;
  logic [DELAY_W-1:0] delayCnt, delayCntNxt;
  logic closeEvt, cmpDoneQ;
  logic delayZero;

  assign refEdge   = refIn & ~refPrev;
  assign fbEdge    = fbIn & ~fbPrev;
  assign delayZero = (resetDelay == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPrev <= 1'b0;
      fbPrev  <= 1'b0;
    end else begin
      refPrev <= refIn;
      fbPrev  <= fbIn;
    end
  end

  always_comb begin
    stateNxt    = state;
    delayCntNxt = delayCnt;
    closeEvt    = 1'b0;
    unique case (state)
      PH_IDLE: begin
        if (refEdge && fbEdge) begin
          closeEvt    = 1'b1;
          stateNxt    = delayZero ? PH_IDLE : PH_RST;
          delayCntNxt = resetDelay;
        end else if (refEdge) begin
          stateNxt = PH_UP;
        end else if (fbEdge) begin
          stateNxt = PH_DN;
        end
      end
      PH_UP: begin
        if (fbEdge) begin
          closeEvt    = 1'b1;
          stateNxt    = delayZero ? PH_IDLE : PH_RST;
          delayCntNxt = resetDelay;
        end
      end
      PH_DN: begin
        if (refEdge) begin
          closeEvt    = 1'b1;
          stateNxt    = delayZero ? PH_IDLE : PH_RST;
          delayCntNxt = resetDelay;
        end
      end
      PH_RST: begin
        if (delayCnt <= DELAY_W'(1)) begin
          stateNxt    = PH_IDLE;
          delayCntNxt = '0;
        end else begin
          delayCntNxt = delayCnt - DELAY_W'(1);
        end
      end
      default: stateNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= PH_IDLE;
      delayCnt <= '0;
      cmpDoneQ <= 1'b0;
    end else begin
      state    <= stateNxt;
      delayCnt <= delayCntNxt;
      cmpDoneQ <= closeEvt;
    end
  end

  always_comb begin
    strobe.upRaw    = (state == PH_UP) || (state == PH_RST);
    strobe.dnRaw    = (state == PH_DN) || (state == PH_RST);
    strobe.oneSided = (state == PH_UP) || (state == PH_DN);
    strobe.cmpDone  = cmpDoneQ;
  end

endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
  parameter int LOCK_COUNT = 16,
  parameter int LOCK_TOL   = 1,
  parameter int WIDTH_W    = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic oneSided,
  input  logic cmpDone,
  output logic lockFlag
);

  localparam int LOCK_W = $clog2(LOCK_COUNT + 1);
  localparam logic [WIDTH_W-1:0] WIDTH_MAX = '1;

  logic [WIDTH_W-1:0] widthCnt;
  logic [LOCK_W-1:0]  tightRun;
  logic               tight;

  assign tight = (widthCnt <= WIDTH_W'(LOCK_TOL));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthCnt <= '0;
      tightRun <= '0;
    end else begin
      if (cmpDone) begin
        widthCnt <= '0;
        if (!tight)
          tightRun <= '0;
        else if (tightRun != LOCK_W'(LOCK_COUNT))
          tightRun <= tightRun + LOCK_W'(1);
      end else if (oneSided && widthCnt != WIDTH_MAX) begin
        widthCnt <= widthCnt + WIDTH_W'(1);
      end
    end
  end

  assign lockFlag = (tightRun == LOCK_W'(LOCK_COUNT));

endmodule

// File: rtl/pfd_datapath.sv
module pfd_datapath
  import pfd_pkg::*;
#(
  parameter int LOCK_COUNT = 16,
  parameter int LOCK_TOL   = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  pfdStrobe_t strobe,
  input  logic       upEnable,
  input  logic       dnEnable,
  input  logic       forceUp,
  input  logic       forceDn,
  input  logic       forceMid,
  output logic       pumpUp,
  output logic       pumpDn,
  output logic       midRequest,
  output logic       lockFlag
);

  logic upNxt, dnNxt, midNxt;
  logic midSel;

  assign midSel = forceMid || (forceUp && forceDn);

  // priority: mid, then single force, then enables over detector
  always_comb begin
    midNxt = 1'b0;
    if (midSel) begin
      upNxt  = 1'b0;
      dnNxt  = 1'b0;
      midNxt = 1'b1;
    end else if (forceUp) begin
      upNxt = 1'b1;
      dnNxt = 1'b0;
    end else if (forceDn) begin
      upNxt = 1'b0;
      dnNxt = 1'b1;
    end else begin
      upNxt = strobe.upRaw && upEnable;
      dnNxt = strobe.dnRaw && dnEnable;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pumpUp     <= 1'b0;
      pumpDn     <= 1'b0;
      midRequest <= 1'b0;
    end else begin
      pumpUp     <= upNxt;
      pumpDn     <= dnNxt;
      midRequest <= midNxt;
    end
  end

  pfd_lock_mon #(
    .LOCK_COUNT(LOCK_COUNT),
    .LOCK_TOL  (LOCK_TOL),
    .WIDTH_W   (8)
  ) lockMon_i (
    .clk     (clk),
    .rstN    (rstN),
    .oneSided(strobe.oneSided),
    .cmpDone (strobe.cmpDone),
    .lockFlag(lockFlag)
  );

endmodule

// File: rtl/phase_comparator.sv
module phase_comparator
  import pfd_pkg::*;
#(
  parameter int DELAY_W    = 3,
  parameter int LOCK_COUNT = 16,
  parameter int LOCK_TOL   = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refIn,
  input  logic               fbIn,
  input  logic [DELAY_W-1:0] resetDelay,
  input  logic               upEnable,
  input  logic               dnEnable,
  input  logic               forceUp,
  input  logic               forceDn,
  input  logic               forceMid,
  output logic               pumpUp,
  output logic               pumpDn,
  output logic               midRequest,
  output logic               lockFlag
);

  pfdStrobe_t strobe;

  pfd_control #(.DELAY_W(DELAY_W)) control_i (
    .clk       (clk),
    .rstN      (rstN),
    .refIn     (refIn),
    .fbIn      (fbIn),
    .resetDelay(resetDelay),
    .strobe    (strobe)
  );

  pfd_datapath #(
    .LOCK_COUNT(LOCK_COUNT),
    .LOCK_TOL  (LOCK_TOL)
  ) datapath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .upEnable  (upEnable),
    .dnEnable  (dnEnable),
    .forceUp   (forceUp),
    .forceDn   (forceDn),
    .forceMid  (forceMid),
    .pumpUp    (pumpUp),
    .pumpDn    (pumpDn),
    .midRequest(midRequest),
    .lockFlag  (lockFlag)
  );

endmodule

// File: rtl/phase_comparator_chk.sv
module phase_comparator_chk (
  input logic clk,
  input logic rstN,
  input logic upEnable,
  input logic dnEnable,
  input logic forceUp,
  input logic forceDn,
  input logic forceMid,
  input logic pumpUp,
  input logic pumpDn,
  input logic midRequest,
  input logic lockFlag
);

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R1
  always @(negedge clk) begin
    if (!rstN) begin
      reset_quiet_chk: assert (!pumpUp && !pumpDn && !midRequest && !lockFlag);
    end
  end

  // R10
  mid_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(forceMid || (forceUp && forceDn))) |-> (midRequest && !pumpUp && !pumpDn));

  // R10
  mid_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    midRequest |-> (!pumpUp && !pumpDn));

  // R9
  force_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(forceUp && !forceDn && !forceMid)) |-> (pumpUp && !pumpDn));

  // R9
  force_dn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(forceDn && !forceUp && !forceMid)) |-> (pumpDn && !pumpUp));

  // R8
  up_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(!upEnable && !forceUp)) |-> !pumpUp);

  // R8
  dn_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(!dnEnable && !forceDn)) |-> !pumpDn);

endmodule

bind phase_comparator phase_comparator_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .upEnable  (upEnable),
  .dnEnable  (dnEnable),
  .forceUp   (forceUp),
  .forceDn   (forceDn),
  .forceMid  (forceMid),
  .pumpUp    (pumpUp),
  .pumpDn    (pumpDn),
  .midRequest(midRequest),
  .lockFlag  (lockFlag)
);

// File: tb/phase_comparator_tb_top.sv
module phase_comparator_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refIn = 1'b0, fbIn = 1'b0;
  logic [2:0] resetDelay = 3'd0;
  logic       upEnable = 1'b1, dnEnable = 1'b1;
  logic       forceUp = 1'b0, forceDn = 1'b0, forceMid = 1'b0;
  logic       pumpUp, pumpDn, midRequest, lockFlag;

  int checks = 0;
  int errors = 0;
  int cntUp, cntDn, cntBoth, cntMid;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  phase_comparator dut_i (
    .clk(clk), .rstN(rstN), .refIn(refIn), .fbIn(fbIn),
    .resetDelay(resetDelay), .upEnable(upEnable), .dnEnable(dnEnable),
    .forceUp(forceUp), .forceDn(forceDn), .forceMid(forceMid),
    .pumpUp(pumpUp), .pumpDn(pumpDn), .midRequest(midRequest), .lockFlag(lockFlag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // drive edge masks over a fixed window, count output cycles
  task automatic runPattern(input logic [23:0] refMask, input logic [23:0] fbMask);
    cntUp = 0; cntDn = 0; cntBoth = 0; cntMid = 0;
    for (int t = 0; t < 24; t++) begin
      refIn = refMask[t];
      fbIn  = fbMask[t];
      tick();
      cntUp   += int'(pumpUp);
      cntDn   += int'(pumpDn);
      cntBoth += int'(pumpUp && pumpDn);
      cntMid  += int'(midRequest);
    end
    refIn = 1'b0;
    fbIn  = 1'b0;
    tick();
  endtask

  task automatic scenario(input bit refLeads, input int sep, input int dly,
                          input bit upE, input bit dnE);
    logic [23:0] lead, lag;
    int expUp, expDn;
    resetDelay = 3'(dly);
    upEnable = upE;
    dnEnable = dnE;
    tick();
    lead = 24'd1;
    lag  = 24'd1 << sep;
    if (refLeads) runPattern(lead, lag);
    else          runPattern(lag, lead);
    expUp = refLeads ? sep + dly : dly;
    expDn = refLeads ? dly : sep + dly;
    if (sep == 0) begin
      check("R5 up width", cntUp, upE ? expUp : 0);
      check("R5 dn width", cntDn, dnE ? expDn : 0);
    end else if (refLeads) begin
      check("R2 up width", cntUp, upE ? expUp : 0);
      check("R2 dn width", cntDn, dnE ? expDn : 0);
    end else begin
      check("R3 up width", cntUp, upE ? expUp : 0);
      check("R3 dn width", cntDn, dnE ? expDn : 0);
    end
    check("R4 overlap", cntBoth, (upE && dnE) ? dly : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 pumpUp", int'(pumpUp), 0);
    check("R1 pumpDn", int'(pumpDn), 0);
    check("R1 midRequest", int'(midRequest), 0);
    check("R1 lockFlag", int'(lockFlag), 0);
    rstN = 1'b1;
    tick();

    // R2 latency: edge presented, rises after two edges
    refIn = 1'b1;
    tick();
    refIn = 1'b0;
    check("R2 latency one edge", int'(pumpUp), 0);
    tick();
    check("R2 latency two edges", int'(pumpUp), 1);
    fbIn = 1'b1;
    tick();
    fbIn = 1'b0;
    repeat (4) tick();

    // R2 R3 R4 R5 sweep over separation, delay and direction
    for (int d = 0; d < 8; d++)
      for (int s = 0; s < 6; s++) begin
        scenario(1'b1, s, d, 1'b1, 1'b1);
        scenario(1'b0, s, d, 1'b1, 1'b1);
      end

    // R8 enable combinations
    for (int e = 0; e < 4; e++) begin
      scenario(1'b1, 3, 2, e[0], e[1]);
      scenario(1'b0, 2, 3, e[0], e[1]);
    end
    upEnable = 1'b1; dnEnable = 1'b1;

    // R6 repeated leading edge absorbed
    resetDelay = 3'd2;
    tick();
    runPattern(24'h000009, 24'h000040);
    check("R6 up width", cntUp, 8);
    check("R6 dn width", cntDn, 2);

    // R7 edges during reset window ignored
    resetDelay = 3'd7;
    tick();
    runPattern(24'h000009, 24'h000022);
    check("R7 up width", cntUp, 8);
    check("R7 dn width", cntDn, 7);
    check("R7 no residual", int'(pumpUp || pumpDn), 0);

    // R8 detector runs while gated
    resetDelay = 3'd1;
    upEnable = 1'b0;
    refIn = 1'b1;
    tick();
    refIn = 1'b0;
    repeat (3) tick();
    check("R8 gated up", int'(pumpUp), 0);
    upEnable = 1'b1;
    tick();
    check("R8 reenabled up", int'(pumpUp), 1);
    fbIn = 1'b1;
    tick();
    fbIn = 1'b0;
    repeat (4) tick();

    // R9 force up over disabled enable
    upEnable = 1'b0;
    forceUp = 1'b1;
    tick();
    check("R9 forced up", int'(pumpUp), 1);
    resetDelay = 3'd3;
    runPattern(24'h0, 24'h1);
    check("R9 up count", cntUp, 24);
    check("R9 dn count", cntDn, 0);
    forceUp = 1'b0;
    upEnable = 1'b1;
    forceDn = 1'b1;
    tick();
    runPattern(24'h1, 24'h0);
    check("R9 force dn up", cntUp, 0);
    check("R9 force dn dn", cntDn, 24);

    // R10 both forces act as mid
    forceUp = 1'b1;
    tick();
    runPattern(24'h1, 24'h4);
    check("R10 pair up", cntUp, 0);
    check("R10 pair dn", cntDn, 0);
    check("R10 pair mid", cntMid, 24);
    forceDn = 1'b0;
    forceMid = 1'b1;
    tick();
    runPattern(24'h4, 24'h1);
    check("R10 mid up", cntUp, 0);
    check("R10 mid count", cntMid, 24);
    forceUp = 1'b0;
    forceMid = 1'b0;
    tick();
    check("R10 release", int'(midRequest), 0);
    runPattern(24'h1, 24'h1);
    repeat (2) tick();

    // R11 lock after 16 tight comparisons
    scenario(1'b1, 3, 1, 1'b1, 1'b1);
    check("R11 wide clears", int'(lockFlag), 0);
    for (int k = 0; k < 15; k++)
      scenario(k[0], k % 2, 1, 1'b1, 1'b1);
    check("R11 fifteen tight", int'(lockFlag), 0);
    scenario(1'b0, 1, 1, 1'b1, 1'b1);
    check("R11 sixteen tight", int'(lockFlag), 1);
    scenario(1'b1, 2, 1, 1'b1, 1'b1);
    check("R11 wide drops lock", int'(lockFlag), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule